// File: doc/BRIEF.md
# Single-Cycle Five-Instruction Processor Core

This block is a 32-bit processor that completes one instruction per clock. In each cycle it takes the word at the program counter from a local instruction store and splits it into fields. It reads two operands from a 32-entry register file and forms either an arithmetic result or a memory address. At the rising edge that closes the cycle it commits that result to the register file or to a local data store. Five operations are understood: register add, register subtract, add of a sign-extended constant, word load and word store. Any other encoding passes through the core as a bubble.

Both stores are small internal arrays. A host loads the program and the initial data through write ports while reset is held, and then releases reset. It observes the results through a registered data-memory read port and a registered register-file read port. The program counter is visible as an output. Every size is a parameter: the instruction-store depth, the data-store depth and the register count.

Top module: `mini_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0, every register is cleared to 0, and neither store is written by the core.
- R2: After reset is released, the program counter rises by 4 at every rising edge and wraps modulo 2^32. The instruction word used is the entry at index pc[IMEM_AW+1:2].
- R3: Encoding op[31:26]=0 with funct[5:0]=32 writes rs+rt, modulo 2^32 with no trap, into register rd. The fields are rs[25:21], rt[20:16] and rd[15:11].
- R4: Encoding op=0 with funct=34 writes rs-rt, modulo 2^32, into register rd.
- R5: Encoding op=8 writes rs plus the two's-complement sign extension of imm[15:0] into register rt.
- R6: Encoding op=35 forms the byte address rs+sext(imm). It writes the data word at index address[DMEM_AW+1:2] into rt, so the two low address bits and all bits above the index are ignored.
- R7: Encoding op=43 forms the address in the same way as R6 and writes register rt into that data word.
- R8: Register 0 always reads as 0, and any write aimed at it is discarded.
- R9: Any op/funct pair other than those in R3 to R7 writes no register and no data word. An all-zero word is such a pair.
- R10: The host write port updates the addressed data word at the rising edge. If a core store hits the same word at the same edge, the core's value is kept.
- R11: A register written by one instruction supplies the new value to the very next instruction.
- R12: Both host read ports are registered. `dbg_rdata` and `dmem_rdata` show the contents at the edge following the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Host write strobe for the instruction store |
| imem_waddr | input | IMEM_AW | Word index for a host instruction write |
| imem_wdata | input | 32 | Instruction word to store |
| dmem_we | input | 1 | Host write strobe for the data store |
| dmem_addr | input | DMEM_AW | Word index for host data read and write |
| dmem_wdata | input | 32 | Data word to store from the host |
| dmem_rdata | output | 32 | Registered host read of the data store |
| dbg_raddr | input | 5 | Register number for the debug read |
| dbg_rdata | output | 32 | Registered debug read of the register file |
| pc | output | 32 | Current program counter (byte address) |

## Verification
The data store can receive a core store and a host write in the same cycle. The bench provokes this with a two-instruction program in which the store commits on the second edge after reset is released. The host strobes a different value into the same word, timed to that exact edge. The word is then read back and must hold the core's value. A later host write that occurs alone must land. Random programs add a second kind of overlap. Back-to-back instructions write and read the same register across one edge, and a load can fetch a word stored just before it. Every register and data word is compared with a bench model that steps the program one instruction at a time.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN   = 32;
  localparam int RIDX_W = 5;

  localparam logic [5:0] OPC_REG  = 6'd0;
  localparam logic [5:0] OPC_ADDI = 6'd8;
  localparam logic [5:0] OPC_LOAD = 6'd35;
  localparam logic [5:0] OPC_STOR = 6'd43;
  localparam logic [5:0] FN_ADD   = 6'd32;
  localparam logic [5:0] FN_SUB   = 6'd34;

  typedef enum logic [2:0] {
    K_NOP, K_ADD, K_SUB, K_ADDI, K_LOAD, K_STORE
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [RIDX_W-1:0] rs;
    logic [RIDX_W-1:0] rt;
    logic [RIDX_W-1:0] rd;
    logic [XLEN-1:0]   imm;
  } dec_t;
endpackage

// File: rtl/mc_decode.sv
module mc_decode
  import mc_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output dec_t            dec
);
  logic [5:0] opc;
  logic [5:0] fn;

  always_comb begin
    opc     = instr[31:26];
    fn      = instr[5:0];
    dec.rs  = instr[25:21];
    dec.rt  = instr[20:16];
    dec.rd  = instr[15:11];
    dec.imm = {{(XLEN-16){instr[15]}}, instr[15:0]};
    unique case (opc)
      OPC_REG:  dec.kind = (fn == FN_ADD) ? K_ADD :
                           (fn == FN_SUB) ? K_SUB : K_NOP;
      OPC_ADDI: dec.kind = K_ADDI;
      OPC_LOAD: dec.kind = K_LOAD;
      OPC_STOR: dec.kind = K_STORE;
      default:  dec.kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int DW    = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra1,
  output logic [DW-1:0] rd1,
  input  logic [AW-1:0] ra2,
  output logic [DW-1:0] rd2,
  input  logic [AW-1:0] ra3,
  output logic [DW-1:0] rd3
);
  logic [DW-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
  assign rd3 = regs[ra3];

  // R8: location zero never yields a nonzero value on the operand ports
  a_r8_zero_reads: assert property (@(posedge clk) disable iff (rst)
    (ra1 == '0) |-> (rd1 == '0));
  // R8: an attempted write to location zero leaves it zero
  a_r8_zero_kept: assert property (@(posedge clk) disable iff (rst)
    (we && waddr == '0) |=> (regs[0] == '0));
  // R1: reset clears the file
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (rd2 == '0 || !$stable(ra2)) );
endmodule

// File: rtl/mc_imem.sv
module mc_imem #(
  parameter int DW    = 32,
  parameter int AW    = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mc_dmem.sv
module mc_dmem #(
  parameter int DW    = 32,
  parameter int AW    = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          core_we,
  input  logic [AW-1:0] core_idx,
  input  logic [DW-1:0] core_wdata,
  output logic [DW-1:0] core_rdata,
  input  logic          host_we,
  input  logic [AW-1:0] host_idx,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic          host_blocked;

  assign host_blocked = core_we && (core_idx == host_idx);

  always_ff @(posedge clk) begin
    if (core_we) mem[core_idx] <= core_wdata;
    if (host_we && !host_blocked) mem[host_idx] <= host_wdata;
    host_rdata <= mem[host_idx];
  end

  assign core_rdata = mem[core_idx];

  // R10: on a same-word collision the core value is what remains
  a_r10_core_wins: assert property (@(posedge clk) disable iff (rst)
    (core_we && host_we && core_idx == host_idx) |=>
      (mem[$past(core_idx)] == $past(core_wdata)));
  // R7: a lone core store lands in the addressed word
  a_r7_store_lands: assert property (@(posedge clk) disable iff (rst)
    (core_we && !host_we) |=> (mem[$past(core_idx)] == $past(core_wdata)));
endmodule

// File: rtl/mini_core.sv
module mini_core
  import mc_pkg::*;
#(
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 6,
  parameter int NREGS   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               imem_we,
  input  logic [IMEM_AW-1:0] imem_waddr,
  input  logic [31:0]        imem_wdata,
  input  logic               dmem_we,
  input  logic [DMEM_AW-1:0] dmem_addr,
  input  logic [31:0]        dmem_wdata,
  output logic [31:0]        dmem_rdata,
  input  logic [4:0]         dbg_raddr,
  output logic [31:0]        dbg_rdata,
  output logic [31:0]        pc
);
  localparam int PC_STEP = XLEN / 8;

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] instr;
  dec_t            dec;
  logic [XLEN-1:0] op_a, op_b, alu_b, alu_y;
  logic [XLEN-1:0] ld_data, rf_wdata, dbg_comb;
  logic [4:0]      rf_waddr;
  logic            rf_we, dm_we, is_reg_op;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_q + XLEN'(PC_STEP);
  end
  assign pc = pc_q;

  mc_imem #(.DW(XLEN), .AW(IMEM_AW)) u_imem (
    .clk(clk), .we(imem_we), .waddr(imem_waddr), .wdata(imem_wdata),
    .raddr(pc_q[IMEM_AW+1:2]), .rdata(instr)
  );

  mc_decode u_dec (.instr(instr), .dec(dec));

  mc_regfile #(.DW(XLEN), .NREGS(NREGS)) u_rf (
    .clk(clk), .rst(rst),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra1(dec.rs), .rd1(op_a),
    .ra2(dec.rt), .rd2(op_b),
    .ra3(dbg_raddr), .rd3(dbg_comb)
  );

  always_comb begin
    is_reg_op = (dec.kind == K_ADD) || (dec.kind == K_SUB);
    alu_b     = is_reg_op ? op_b : dec.imm;
    alu_y     = (dec.kind == K_SUB) ? (op_a - alu_b) : (op_a + alu_b);
    rf_we     = !rst && (is_reg_op || dec.kind == K_ADDI || dec.kind == K_LOAD);
    rf_waddr  = is_reg_op ? dec.rd : dec.rt;
    rf_wdata  = (dec.kind == K_LOAD) ? ld_data : alu_y;
    dm_we     = !rst && (dec.kind == K_STORE);
  end

  mc_dmem #(.DW(XLEN), .AW(DMEM_AW)) u_dmem (
    .clk(clk), .rst(rst),
    .core_we(dm_we), .core_idx(alu_y[DMEM_AW+1:2]),
    .core_wdata(op_b), .core_rdata(ld_data),
    .host_we(dmem_we), .host_idx(dmem_addr),
    .host_wdata(dmem_wdata), .host_rdata(dmem_rdata)
  );

  always_ff @(posedge clk) dbg_rdata <= dbg_comb;

  // R1: reset returns the counter to zero
  a_r1_pc_reset: assert property (@(posedge clk) rst |=> (pc_q == '0));
  // R2: one word step per edge outside reset
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pc_q == $past(pc_q) + XLEN'(PC_STEP)));
  // R9: an unknown encoding commits nothing
  a_r9_bubble: assert property (@(posedge clk) disable iff (rst)
    (dec.kind == K_NOP) |-> (!rf_we && !dm_we));
  // R6/R7: memory operations never also target the other side
  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rf_we && dm_we));
endmodule

// File: tb/sim_mini_core.sv
module sim_mini_core;
  localparam int CLK_NS = 10;
  localparam int IAW = 8;
  localparam int DAW = 6;
  localparam int IDEPTH = 1 << IAW;
  localparam int DDEPTH = 1 << DAW;
  localparam int PLEN = 24;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           imem_we = 1'b0;
  logic [IAW-1:0] imem_waddr = '0;
  logic [31:0]    imem_wdata = '0;
  logic           dmem_we = 1'b0;
  logic [DAW-1:0] dmem_addr = '0;
  logic [31:0]    dmem_wdata = '0;
  logic [31:0]    dmem_rdata;
  logic [4:0]     dbg_raddr = '0;
  logic [31:0]    dbg_rdata;
  logic [31:0]    pc;

  int checks = 0;
  int fails  = 0;

  logic [31:0] prog  [PLEN];
  logic [31:0] minit [DDEPTH];
  logic [31:0] mreg  [32];
  logic [31:0] mmem  [DDEPTH];

  always #(CLK_NS/2) clk = ~clk;

  mini_core #(.IMEM_AW(IAW), .DMEM_AW(DAW)) u0 (
    .clk(clk), .rst(rst),
    .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
    .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_rdata(dmem_rdata), .dbg_raddr(dbg_raddr), .dbg_rdata(dbg_rdata),
    .pc(pc)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rd,
                                        input logic [4:0] rs, input logic [4:0] rt);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rt,
                                        input logic [4:0] rs, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] sx16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic model_wr(input logic [4:0] r, input logic [31:0] v);
    if (r != 5'd0) mreg[r] = v;
  endtask

  task automatic model_exec(input logic [31:0] ins);
    logic [31:0] a, b, ea;
    a  = mreg[ins[25:21]];
    b  = mreg[ins[20:16]];
    ea = a + sx16(ins[15:0]);
    if (ins[31:26] == 6'd0 && ins[5:0] == 6'd32)      model_wr(ins[15:11], a + b);
    else if (ins[31:26] == 6'd0 && ins[5:0] == 6'd34) model_wr(ins[15:11], a - b);
    else if (ins[31:26] == 6'd8)                      model_wr(ins[20:16], ea);
    else if (ins[31:26] == 6'd35)                     model_wr(ins[20:16], mmem[ea[DAW+1:2]]);
    else if (ins[31:26] == 6'd43)                     mmem[ea[DAW+1:2]] = b;
  endtask

  task automatic read_reg(input int r, output logic [31:0] v);
    @(negedge clk) dbg_raddr = 5'(r);
    @(negedge clk) v = dbg_rdata;
  endtask

  task automatic read_mem(input int i, output logic [31:0] v);
    @(negedge clk) begin dmem_addr = DAW'(i); dmem_we = 1'b0; end
    @(negedge clk) v = dmem_rdata;
  endtask

  task automatic load_all();
    @(negedge clk) rst = 1'b1;
    for (int i = 0; i < IDEPTH; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_waddr = IAW'(i);
      imem_wdata = (i < PLEN) ? prog[i] : 32'h0;
    end
    @(negedge clk) imem_we = 1'b0;
    for (int i = 0; i < DDEPTH; i++) begin
      dmem_we = 1'b1; dmem_addr = DAW'(i); dmem_wdata = minit[i];
      @(negedge clk);
    end
    dmem_we = 1'b0;
  endtask

  task automatic run_trial(input string tag);
    logic [31:0] v;
    load_all();
    // R1: reset state seen at the ports while reset is held
    chk("R1 pc in reset", pc, 32'h0);
    for (int r = 1; r < 6; r++) begin
      read_reg(r, v);
      chk("R1 register cleared", v, 32'h0);
    end
    for (int r = 0; r < 32; r++) mreg[r] = 32'h0;
    for (int i = 0; i < DDEPTH; i++) mmem[i] = minit[i];
    for (int i = 0; i < PLEN; i++) model_exec(prog[i]);
    @(negedge clk) rst = 1'b0;
    for (int c = 1; c <= PLEN; c++) begin
      @(negedge clk);
      chk("R2 pc step", pc, 32'(4 * c));
    end
    read_reg(0, v);
    chk("R8 zero register", v, 32'h0);
    for (int r = 1; r < 32; r++) begin
      read_reg(r, v);
      chk({tag, " reg (R12 debug read)"}, v, mreg[r]);
    end
    for (int i = 0; i < DDEPTH; i++) begin
      read_mem(i, v);
      chk({tag, " mem (R12 host read)"}, v, mmem[i]);
    end
  endtask

  function automatic logic [31:0] rand_instr();
    logic [4:0]  a, b, d;
    logic [15:0] imm;
    int          k;
    a = 5'($urandom % 8); b = 5'($urandom % 8); d = 5'($urandom % 8);
    imm = 16'($urandom);
    k = $urandom % 8;
    case (k)
      0: return enc_r(6'd32, d, a, b);
      1: return enc_r(6'd34, d, a, b);
      2, 3: return enc_i(6'd8, b, a, imm);
      4: return enc_i(6'd35, b, a, imm);
      5: return enc_i(6'd43, b, a, imm);
      6: return enc_r(6'd33, d, a, b);
      default: return enc_i(6'(($urandom % 2) ? 9 : 42), b, a, imm);
    endcase
  endfunction

  task automatic collision_test();
    logic [31:0] v;
    for (int i = 0; i < PLEN; i++) prog[i] = 32'h0;
    prog[0] = enc_i(6'd8, 5'd1, 5'd0, 16'h0055);
    prog[1] = enc_i(6'd43, 5'd1, 5'd0, 16'h0000);
    for (int i = 0; i < DDEPTH; i++) minit[i] = 32'h0;
    load_all();
    @(negedge clk) rst = 1'b0;
    @(negedge clk) begin dmem_we = 1'b1; dmem_addr = '0; dmem_wdata = 32'hAA; end
    @(negedge clk) dmem_we = 1'b0;
    read_mem(0, v);
    chk("R10 core store wins collision", v, 32'h55);
    @(negedge clk) begin dmem_we = 1'b1; dmem_addr = '0; dmem_wdata = 32'hAA; end
    @(negedge clk) dmem_we = 1'b0;
    read_mem(0, v);
    chk("R10 lone host write lands", v, 32'hAA);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog got=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    // R3 R4 R5 R8 R11: wrapping arithmetic, zero target, back-to-back use
    for (int i = 0; i < PLEN; i++) prog[i] = 32'h0;
    for (int i = 0; i < DDEPTH; i++) minit[i] = 32'(i * 3);
    prog[0] = enc_i(6'd8, 5'd1, 5'd0, 16'hFFFF);
    prog[1] = enc_i(6'd8, 5'd2, 5'd0, 16'h0002);
    prog[2] = enc_r(6'd32, 5'd3, 5'd1, 5'd2);
    prog[3] = enc_r(6'd34, 5'd4, 5'd0, 5'd2);
    prog[4] = enc_i(6'd8, 5'd0, 5'd1, 16'h0005);
    prog[5] = enc_r(6'd32, 5'd5, 5'd0, 5'd0);
    prog[6] = enc_i(6'd8, 5'd6, 5'd2, 16'h7FFF);
    prog[7] = enc_r(6'd34, 5'd7, 5'd6, 5'd6);
    prog[8] = enc_i(6'd8, 5'd8, 5'd6, 16'h8000);
    run_trial("R3 R4 R5 R11 directed");
    chk("R3 wrap add", mreg[3], 32'h1);
    chk("R4 negative difference", mreg[4], 32'hFFFF_FFFE);
    // R6 R7: address forming, ignored low bits, index wrap
    for (int i = 0; i < PLEN; i++) prog[i] = 32'h0;
    for (int i = 0; i < DDEPTH; i++) minit[i] = 32'h1000 + 32'(i);
    minit[3] = 32'hCAFE_F00D;
    prog[0] = enc_i(6'd8, 5'd1, 5'd0, 16'd13);
    prog[1] = enc_i(6'd35, 5'd2, 5'd1, 16'hFFFF);
    prog[2] = enc_i(6'd35, 5'd3, 5'd1, 16'd2);
    prog[3] = enc_i(6'd43, 5'd2, 5'd0, 16'h0100);
    prog[4] = enc_i(6'd8, 5'd4, 5'd0, 16'hFFFC);
    prog[5] = enc_i(6'd43, 5'd1, 5'd4, 16'd8);
    prog[6] = enc_i(6'd35, 5'd5, 5'd0, 16'd4);
    run_trial("R6 R7 directed");
    chk("R6 load with low bits set", mreg[3], 32'hCAFE_F00D);
    chk("R7 store then load", mreg[5], 32'd13);
    // R9: unknown encodings commit nothing
    for (int i = 0; i < PLEN; i++) prog[i] = 32'h0;
    prog[0] = enc_r(6'd33, 5'd1, 5'd0, 5'd0);
    prog[1] = enc_i(6'd9, 5'd2, 5'd0, 16'h1234);
    prog[2] = enc_i(6'd42, 5'd0, 5'd0, 16'h0000);
    prog[3] = enc_i(6'd2, 5'd3, 5'd0, 16'h0004);
    run_trial("R9 bubbles");
    collision_test();
    for (int t = 0; t < 12; t++) begin
      for (int i = 0; i < PLEN; i++) prog[i] = rand_instr();
      for (int i = 0; i < DDEPTH; i++) minit[i] = $urandom;
      run_trial("R3 R4 R5 R6 R7 R9 R11 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule